// File: doc/BRIEF.md
# DMA Channel Control and Status Word

This block holds the control and status word of a single DMA channel. Software reaches it over a 32-bit register bus. A single word mixes three kinds of bit. Some are plain read/write fields. Some flags are cleared by writing 1 to them. One bit makes the whole channel clear itself, and one bit is accepted but does nothing. The transfer engine sits next to the block. It reports the end of each descriptor and the end of a whole descriptor chain. The block turns those reports into status flags and an interrupt line.

When a write turns the active bit on, the block sends the engine a one-cycle start pulse. Whenever software clears the channel interrupt, the block also sends a one-cycle strobe. That strobe clears the channel's bit in a global interrupt status word, which lives outside this block. The block also holds the channel's descriptor address, which software writes and the self-clear resets.

All outputs are registered. A write or an engine event sampled on one rising edge shows on the outputs in the cycle that follows that edge.

Top module: `dma_chan_csr`

## Requirements
- R1: While rstN is low and after its release with no activity, rdData is 0, descAddr is 0 and irq, startPulse and gIntClr are 0.
- R2: A write replaces exactly the bits of mask 0x30FF0001 (bit 0 active, bits 16..23, bits 28..29) with the written value. Other bits keep their state. Only those bits, end (bit 1), interrupt (bit 2) and paused (bit 4) ever read as 1. Bits 5, 8, 30 and 31 always read 0.
- R3: Writing 1 to bit 1 clears the end flag.
- R4: Writing 1 to bit 2 clears the interrupt flag and drops irq. In the next cycle gIntClr pulses high for one cycle.
- R5: Writing 1 to bit 31 clears the whole word and zeroes descAddr. The masked update of R2 is then applied on top, and gIntClr pulses.
- R6: startPulse is high for one cycle after a write with bit 0 set, but only if the stored active bit was 0 or the same write carried bit 31. A write that keeps an already active channel active gives no pulse.
- R7: A descDone event sets the end flag. If descIntEn is also high, it sets the interrupt flag, and irq follows that flag until software clears it.
- R8: A chainDone event clears the active bit and sets the paused bit.
- R9: Bit 30 (abort) has no effect. A write with it behaves exactly like the same write without it.
- R10: An address write loads descAddr from addrWrData. A bit-31 write in the same cycle wins, leaving descAddr at 0.
- R11: When engine events and a bus write fall in the same cycle, the events are applied first. The clears and masked update of the write are applied after them, so a same-cycle write-1 clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control/status word |
| wrData | input | 32 | Write data for the control/status word |
| addrWrEn | input | 1 | Write strobe for the descriptor address |
| addrWrData | input | ADDR_W | Descriptor address write data |
| descDone | input | 1 | Engine finished one descriptor |
| descIntEn | input | 1 | Interrupt-enable of the finished descriptor |
| chainDone | input | 1 | Engine finished the descriptor chain |
| rdData | output | 32 | Current control/status word |
| descAddr | output | ADDR_W | Current descriptor address |
| startPulse | output | 1 | One-cycle start request to the engine |
| irq | output | 1 | Channel interrupt request |
| gIntClr | output | 1 | One-cycle clear strobe for the global interrupt status bit |

## Verification
The bench walks a single 1 and several dense patterns across all 32 write bits. A design with a wrong mask would either keep bits that should read 0, such as the abort and self-clear bits, or lose read/write field bits. It repeats active writes to look for a missing start pulse or a duplicated one, including the case where the self-clear bit forces a restart of a channel that is already running. It sweeps every combination of the three engine events against every write-1-clear pattern in the same cycle. A design with the wrong order would drop a clear, or leave irq set after software had cleared it.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int CSR_W     = 32;
  localparam int BIT_ACT   = 0;
  localparam int BIT_END   = 1;
  localparam int BIT_INT   = 2;
  localparam int BIT_PAUSE = 4;
  localparam int BIT_ABORT = 30;
  localparam int BIT_RST   = 31;

  // read/write field bits replaced by every write
  localparam logic [CSR_W-1:0] RW_MASK = 32'h30FF_0001;
  // flag bits driven by engine events
  localparam logic [CSR_W-1:0] FLAG_MASK =
    (32'h1 << BIT_END) | (32'h1 << BIT_INT) | (32'h1 << BIT_PAUSE);
  localparam logic [CSR_W-1:0] KEEP_MASK = RW_MASK | FLAG_MASK;

  typedef struct packed {
    logic setEnd;
    logic setInt;
    logic finish;
    logic doReset;
    logic clrEnd;
    logic clrInt;
    logic loadMask;
    logic loadAddr;
  } csrStrobes_t;
endpackage

// File: rtl/dma_csr_control.sv
module dma_csr_control
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  input  logic             addrWrEn,
  input  logic             descDone,
  input  logic             descIntEn,
  input  logic             chainDone,
  input  logic             storedActive,
  output csrStrobes_t      strb,
  output logic             startPulse,
  output logic             gIntClr
);
  logic unusedWrBits;
  logic startNext;
  logic clrNext;

  assign unusedWrBits = ^wrData;

  always_comb begin
    strb          = '0;
    strb.setEnd   = descDone;
    strb.setInt   = descDone & descIntEn;
    strb.finish   = chainDone;
    strb.doReset  = wrEn & wrData[BIT_RST];
    strb.clrEnd   = wrEn & wrData[BIT_END];
    strb.clrInt   = wrEn & wrData[BIT_INT];
    strb.loadMask = wrEn;
    strb.loadAddr = addrWrEn;
  end

  // 0->1 edge of active, or forced restart through self-clear
  assign startNext = wrEn & wrData[BIT_ACT] & (~storedActive | wrData[BIT_RST]);
  assign clrNext   = wrEn & (wrData[BIT_INT] | wrData[BIT_RST]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      gIntClr    <= 1'b0;
    end else begin
      startPulse <= startNext;
      gIntClr    <= clrNext;
    end
  end
endmodule

// File: rtl/dma_csr_datapath.sv
module dma_csr_datapath
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       strb,
  input  logic [CSR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic [CSR_W-1:0]  csrQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              storedActive,
  output logic              intFlag
);
  logic [CSR_W-1:0]  evtStage;
  logic [CSR_W-1:0]  clrStage;
  logic [CSR_W-1:0]  csrNext;
  logic [ADDR_W-1:0] addrNext;

  // stage 1: engine events
  always_comb begin
    evtStage = csrQ;
    if (strb.setEnd) evtStage[BIT_END] = 1'b1;
    if (strb.setInt) evtStage[BIT_INT] = 1'b1;
    if (strb.finish) begin
      evtStage[BIT_ACT]   = 1'b0;
      evtStage[BIT_PAUSE] = 1'b1;
    end
  end

  // stage 2: self-clear and write-1-to-clear
  always_comb begin
    clrStage = evtStage;
    if (strb.doReset) clrStage = '0;
    if (strb.clrEnd)  clrStage[BIT_END] = 1'b0;
    if (strb.clrInt)  clrStage[BIT_INT] = 1'b0;
  end

  // stage 3: masked field update
  always_comb begin
    csrNext = clrStage;
    if (strb.loadMask) csrNext = (clrStage & ~RW_MASK) | (wrData & RW_MASK);
    csrNext = csrNext & KEEP_MASK;
  end

  always_comb begin
    addrNext = addrQ;
    if (strb.loadAddr) addrNext = addrWrData;
    if (strb.doReset)  addrNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrQ  <= '0;
      addrQ <= '0;
    end else begin
      csrQ  <= csrNext;
      addrQ <= addrNext;
    end
  end

  assign storedActive = csrQ[BIT_ACT];
  assign intFlag      = csrQ[BIT_INT];
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CSR_W-1:0]  wrData,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              descDone,
  input  logic              descIntEn,
  input  logic              chainDone,
  output logic [CSR_W-1:0]  rdData,
  output logic [ADDR_W-1:0] descAddr,
  output logic              startPulse,
  output logic              irq,
  output logic              gIntClr
);
  csrStrobes_t strb;
  logic        storedActive;

  dma_csr_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .addrWrEn     (addrWrEn),
    .descDone     (descDone),
    .descIntEn    (descIntEn),
    .chainDone    (chainDone),
    .storedActive (storedActive),
    .strb         (strb),
    .startPulse   (startPulse),
    .gIntClr      (gIntClr)
  );

  dma_csr_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .addrWrData   (addrWrData),
    .csrQ         (rdData),
    .addrQ        (descAddr),
    .storedActive (storedActive),
    .intFlag      (irq)
  );
endmodule

// File: rtl/dma_chan_csr_checker.sv
module dma_chan_csr_checker
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CSR_W-1:0]  wrData,
  input logic              addrWrEn,
  input logic [ADDR_W-1:0] addrWrData,
  input logic              descDone,
  input logic              descIntEn,
  input logic              chainDone,
  input logic [CSR_W-1:0]  rdData,
  input logic [ADDR_W-1:0] descAddr,
  input logic              startPulse,
  input logic              irq,
  input logic              gIntClr
);
  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[BIT_RST] |=> rdData == ($past(wrData) & RW_MASK) && descAddr == '0);

  a_r6_start_from_write: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(wrEn && wrData[BIT_ACT]));

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(descDone && descIntEn));

  a_r3_end_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[BIT_END] |=> !rdData[BIT_END]);

  a_r4_global_clear: assert property (@(posedge clk) disable iff (!rstN)
    gIntClr |-> $past(wrEn && (wrData[BIT_INT] || wrData[BIT_RST])));

  a_r8_chain_end: assert property (@(posedge clk) disable iff (!rstN)
    chainDone && !wrEn |=> !rdData[BIT_ACT] && rdData[BIT_PAUSE]);

  a_r10_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEn && !(wrEn && wrData[BIT_RST]) |=> descAddr == $past(addrWrData));

  a_r2_dead_bits: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData & ~KEEP_MASK) == '0);
endmodule

bind dma_chan_csr dma_chan_csr_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dma_chan_csr_tb_top.sv
module dma_chan_csr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] M_RW   = 32'h30FF_0001;
  localparam logic [31:0] M_KEEP = 32'h30FF_0017;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic          addrWrEn = 1'b0;
  logic [AW-1:0] addrWrData = '0;
  logic          descDone = 1'b0;
  logic          descIntEn = 1'b0;
  logic          chainDone = 1'b0;
  logic [31:0]   rdData;
  logic [AW-1:0] descAddr;
  logic          startPulse;
  logic          irq;
  logic          gIntClr;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0]   expCsr = '0;
  logic [AW-1:0] expAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .descDone(descDone), .descIntEn(descIntEn), .chainDone(chainDone),
    .rdData(rdData), .descAddr(descAddr), .startPulse(startPulse),
    .irq(irq), .gIntClr(gIntClr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input logic we, input logic [31:0] d,
                      input logic dd, input logic ie, input logic cd,
                      input logic aw, input logic [AW-1:0] ad, input string tag);
    logic [31:0] e;
    logic expStart, expClr;
    wrEn = we; wrData = d; descDone = dd; descIntEn = ie; chainDone = cd;
    addrWrEn = aw; addrWrData = ad;
    e = expCsr;
    if (dd) e[1] = 1'b1;
    if (dd && ie) e[2] = 1'b1;
    if (cd) begin e[0] = 1'b0; e[4] = 1'b1; end
    expStart = we && d[0] && (!expCsr[0] || d[31]);
    expClr   = we && (d[2] || d[31]);
    if (aw) expAddr = ad;
    if (we) begin
      if (d[31]) begin e = '0; expAddr = '0; end
      if (d[1]) e[1] = 1'b0;
      if (d[2]) e[2] = 1'b0;
      e = (e & ~M_RW) | (d & M_RW);
    end
    expCsr = e & M_KEEP;
    @(negedge clk);
    check(tag, "rdData", rdData, expCsr);
    check(tag, "descAddr", descAddr, expAddr);
    check(tag, "startPulse", {31'b0, startPulse}, {31'b0, expStart});
    check(tag, "gIntClr", {31'b0, gIntClr}, {31'b0, expClr});
    check(tag, "irq", {31'b0, irq}, {31'b0, expCsr[2]});
    wrEn = 1'b0; wrData = '0; descDone = 1'b0; descIntEn = 1'b0;
    chainDone = 1'b0; addrWrEn = 1'b0; addrWrData = '0;
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", "rdData in reset", rdData, 32'h0);
    check("R1", "irq in reset", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    idle("R1");
    idle("R1");

    // R2 walking one and dense patterns, abort bit included
    for (int i = 0; i < 32; i++) wr(32'h1 << i, "R2");
    wr(32'hFFFF_FFFF, "R2");
    wr(32'h5555_AAAA, "R2");
    wr(32'hCF00_FFFE, "R2");
    wr(32'h0000_0000, "R2");

    // R6 start edge
    wr(32'h0000_0001, "R6");
    wr(32'h0000_0001, "R6");
    wr(32'h0012_0001, "R6");
    wr(32'h0000_0000, "R6");
    wr(32'h0000_0001, "R6");
    wr(32'h8000_0001, "R6");

    // R9 abort on an active channel behaves like the plain write
    wr(32'h4000_0001, "R9");
    wr(32'h4030_0001, "R9");

    // R7 descriptor completion and sticky irq
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
    step(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7");
    idle("R7");
    idle("R7");
    // R8 chain end
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R8");
    // R4 and R3 write-1 clears
    wr(32'h0000_0004, "R4");
    wr(32'h0000_0002, "R3");

    // R10 descriptor address
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEE0, "R10");
    idle("R10");
    wr(32'h8000_0000, "R10");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5670, "R10");
    step(1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'hABCD_0000, "R10");
    // R5 self-clear wipes flags set just before it
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0040, "R5");
    wr(32'h8020_0000, "R5");

    // R11 every event combination against every clear pattern
    for (int ev = 0; ev < 8; ev++) begin
      for (int w = 0; w < 4; w++) begin
        step(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R11");
        step(1'b1, 32'h00A5_0000 | (32'(w) << 1), ev[0], ev[1], ev[2],
             1'b0, '0, "R11");
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule